// File: doc/BRIEF.md
# PCI Slot Interrupt Router

The router takes interrupt events from PCI slots and turns them into one CPU interrupt. Each event names a slot, one of that slot's four interrupt pins and the pin level. A fixed, slot-dependent rule converts the slot and pin into an internal line number. Most lines sit at or above a base of 32. The block registers that line number on `line_o` so the rest of the interrupt controller can pick it up.

Two 32-bit configuration vectors control the CPU output. Bit k of each vector governs internal line 32+k. If the edge bit for the line is set, the event raises `cpu_irq_o` for exactly one clock. If the edge bit is clear, the line is level type, and `cpu_irq_o` takes the value of the polarity bit for that line and keeps it. Some events map to lines with no configuration bit, because their slots are passed through without translation. Such events still update `line_o`, but they leave the CPU output alone.

Top module: `pci_irq_router`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first event, `line_o` is 0 and `cpu_irq_o` is 0.
- R2: For slot 5, an event on pin n gives line 32 + (n mod 4).
- R3: Slot 6 gives line 36 and slot 7 gives line 37, whatever the pin.
- R4: For slots 8 through 12, an event on pin n gives line 38 + (slot - 8 + n), which covers lines 38 to 45.
- R5: Every other slot passes the pin number through unchanged, so the line is n, in the range 0 to 3.
- R6: `line_o` takes the mapped line one clock after the cycle in which `evt_i` is sampled high. It keeps that value while `evt_i` is low.
- R7: When the edge bit of the event's line is set, `cpu_irq_o` is 1 in the cycle after the event and 0 in the cycle after that, unless another event arrives.
- R8: When the edge bit of the event's line is clear, `cpu_irq_o` becomes that line's polarity bit one clock after the event. It holds that value until the next accepted event.
- R9: Configuration is looked up at bit index (line - 32) of `edge_sel_i` and `pol_sel_i`. No other bit has any effect.
- R10: An event whose line falls outside 32 to 63 leaves `cpu_irq_o` unchanged, even when every edge and polarity bit is set.
- R11: `level_i` has no effect on `cpu_irq_o` or `line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Interrupt event strobe, one cycle per event |
| slot_i | input | 5 | Slot number of the event |
| pin_i | input | 2 | Pin index, 0 to 3 for pins A to D |
| level_i | input | 1 | Reported pin level; has no effect |
| edge_sel_i | input | 32 | Per-line edge select: 1 = pulse, 0 = level |
| pol_sel_i | input | 32 | Per-line polarity used in level mode |
| line_o | output | 8 | Registered internal line number of the last event |
| cpu_irq_o | output | 1 | Registered CPU interrupt output |

## Verification
The assertions assume that `edge_sel_i` and `pol_sel_i` are stable during the cycle of an event, and that `slot_i` and `pin_i` are valid whenever `evt_i` is high. The bench changes configuration only at falling edges, and only while `evt_i` is low. The pulse-end property assumes no event arrives in the cycle right after an edge event. Every edge-mode stimulus is therefore followed by at least one idle cycle before the next event.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

  localparam int SLOT_W_D    = 5;
  localparam int PIN_W_D     = 2;
  localparam int LINE_W_D    = 8;
  localparam int NUM_LINES_D = 32;
  localparam int LINE_BASE_D = 32;

  localparam int SHARED_SLOT = 5;
  localparam int SOLO_A_SLOT = 6;
  localparam int SOLO_B_SLOT = 7;
  localparam int ADDIN_FIRST = 8;
  localparam int ADDIN_LAST  = 12;

  localparam int SOLO_A_IDX  = 4;
  localparam int SOLO_B_IDX  = 5;
  localparam int ADDIN_IDX   = 6;
  localparam int PINS_PER_SL = 4;

  typedef enum logic [2:0] {
    MAP_SHARED,
    MAP_SOLO_A,
    MAP_SOLO_B,
    MAP_ADDIN,
    MAP_PASS
  } map_kind_e;

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import pci_irq_router_pkg::*;
#(
  parameter int SLOT_W    = SLOT_W_D,
  parameter int PIN_W     = PIN_W_D,
  parameter int LINE_W    = LINE_W_D,
  parameter int LINE_BASE = LINE_BASE_D
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output map_kind_e         kind_o,
  output logic [LINE_W-1:0] line_o
);

  int slot_n;
  int pin_n;
  int line_n;

  always_comb begin
    slot_n = int'(slot_i);
    pin_n  = int'(pin_i);
    if (slot_n == SHARED_SLOT)                              kind_o = MAP_SHARED;
    else if (slot_n == SOLO_A_SLOT)                         kind_o = MAP_SOLO_A;
    else if (slot_n == SOLO_B_SLOT)                         kind_o = MAP_SOLO_B;
    else if (slot_n >= ADDIN_FIRST && slot_n <= ADDIN_LAST) kind_o = MAP_ADDIN;
    else                                                    kind_o = MAP_PASS;
  end

  always_comb begin
    unique case (kind_o)
      MAP_SHARED: line_n = LINE_BASE + (pin_n % PINS_PER_SL);
      MAP_SOLO_A: line_n = LINE_BASE + SOLO_A_IDX;
      MAP_SOLO_B: line_n = LINE_BASE + SOLO_B_IDX;
      // add-in slots rotate pins across neighbouring lines
      MAP_ADDIN:  line_n = LINE_BASE + ADDIN_IDX + (slot_n - ADDIN_FIRST + pin_n);
      default:    line_n = pin_n;
    endcase
    line_o = LINE_W'(line_n);
  end

endmodule

// File: rtl/irq_cfg_lookup.sv
module irq_cfg_lookup
  import pci_irq_router_pkg::*;
#(
  parameter int LINE_W    = LINE_W_D,
  parameter int NUM_LINES = NUM_LINES_D,
  parameter int LINE_BASE = LINE_BASE_D
) (
  input  logic                 evt_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic [NUM_LINES-1:0] edge_sel_i,
  input  logic [NUM_LINES-1:0] pol_sel_i,
  output logic                 hit_o,
  output logic                 edge_o,
  output logic                 pol_o
);

  int                 off;
  logic               in_range;
  logic [NUM_LINES-1:0] sel;

  always_comb begin
    off      = int'(line_i) - LINE_BASE;
    in_range = (off >= 0) && (off < NUM_LINES);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
    assign sel[g] = in_range && (off == g);
  end

  assign hit_o  = evt_i && in_range;
  assign edge_o = |(sel & edge_sel_i);
  assign pol_o  = |(sel & pol_sel_i);

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic edge_i,
  input  logic pol_i,
  output logic irq_o
);

  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (hit_i && edge_i) begin
      irq_o   <= 1'b1;
      pulse_q <= 1'b1;
    end else if (hit_i) begin
      irq_o   <= pol_i;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      irq_o   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int SLOT_W    = SLOT_W_D,
  parameter int PIN_W     = PIN_W_D,
  parameter int LINE_W    = LINE_W_D,
  parameter int NUM_LINES = NUM_LINES_D,
  parameter int LINE_BASE = LINE_BASE_D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [PIN_W-1:0]     pin_i,
  input  logic                 level_i,
  input  logic [NUM_LINES-1:0] edge_sel_i,
  input  logic [NUM_LINES-1:0] pol_sel_i,
  output logic [LINE_W-1:0]    line_o,
  output logic                 cpu_irq_o
);

  map_kind_e         kind_w;
  logic [LINE_W-1:0] line_w;
  logic              hit_w;
  logic              edge_w;
  logic              pol_w;
  logic              unused_level;

  // pin level is reported but does not steer the output
  assign unused_level = level_i;

  irq_slot_map #(
    .SLOT_W(SLOT_W), .PIN_W(PIN_W), .LINE_W(LINE_W), .LINE_BASE(LINE_BASE)
  ) u_map (
    .slot_i (slot_i),
    .pin_i  (pin_i),
    .kind_o (kind_w),
    .line_o (line_w)
  );

  irq_cfg_lookup #(
    .LINE_W(LINE_W), .NUM_LINES(NUM_LINES), .LINE_BASE(LINE_BASE)
  ) u_lkp (
    .evt_i      (evt_i),
    .line_i     (line_w),
    .edge_sel_i (edge_sel_i),
    .pol_sel_i  (pol_sel_i),
    .hit_o      (hit_w),
    .edge_o     (edge_w),
    .pol_o      (pol_w)
  );

  irq_out_gen u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_w),
    .edge_i (edge_w),
    .pol_i  (pol_w),
    .irq_o  (cpu_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_o <= '0;
    else if (evt_i) line_o <= line_w;
  end

endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk
  import pci_irq_router_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  evt_i,
  input logic [SLOT_W_D-1:0]   slot_i,
  input logic [PIN_W_D-1:0]    pin_i,
  input logic [LINE_W_D-1:0]   line_o,
  input logic                  cpu_irq_o,
  input logic                  hit_i,
  input logic                  edge_i,
  input logic                  pol_i
);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (line_o == '0 && !cpu_irq_o));

  p_addin_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && slot_i >= SLOT_W_D'(ADDIN_FIRST) && slot_i <= SLOT_W_D'(ADDIN_LAST))
    |=> (line_o >= LINE_W_D'(38) && line_o <= LINE_W_D'(45)));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && slot_i < SLOT_W_D'(SHARED_SLOT)) |=> line_o == LINE_W_D'($past(pin_i)));

  p_line_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(line_o));

  p_pulse_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && edge_i) |=> cpu_irq_o);

  p_pulse_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && edge_i) ##1 !hit_i |=> !cpu_irq_o);

  p_level_pol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !edge_i) |=> cpu_irq_o == $past(pol_i));

  p_quiet_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !cpu_irq_o) |=> !cpu_irq_o);

endmodule

bind pci_irq_router pci_irq_router_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .slot_i    (slot_i),
  .pin_i     (pin_i),
  .line_o    (line_o),
  .cpu_irq_o (cpu_irq_o),
  .hit_i     (hit_w),
  .edge_i    (edge_w),
  .pol_i     (pol_w)
);

// File: tb/sim_pci_irq_router.sv
`timescale 1ns/1ps
module sim_pci_irq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic [4:0]  slot = '0;
  logic [1:0]  pin = '0;
  logic        lvl = 1'b0;
  logic [31:0] edge_sel = '0;
  logic [31:0] pol_sel = '0;
  logic [7:0]  line;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .slot_i(slot), .pin_i(pin),
    .level_i(lvl), .edge_sel_i(edge_sel), .pol_sel_i(pol_sel),
    .line_o(line), .cpu_irq_o(irq)
  );

  // slot, pin, expected line
  localparam int NV = 16;
  localparam logic [4:0] V_SLOT [NV] = '{5, 5, 5, 6, 6, 7, 7, 8, 8, 10, 11, 12, 12, 0, 4, 31};
  localparam logic [1:0] V_PIN  [NV] = '{0, 2, 3, 0, 3, 1, 2, 0, 3, 1,  2,  0,  3,  2, 1, 3};
  localparam logic [7:0] V_LINE [NV] = '{32, 34, 35, 36, 36, 37, 37, 38, 41, 41, 43, 42, 45, 2, 1, 3};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input logic [4:0] s, input logic [1:0] p, input logic l);
    @(negedge clk);
    slot = s; pin = p; lvl = l; evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    string tag;
    idle(3);
    chk(line, 0, "R1 line in reset");
    chk(irq, 0, "R1 irq in reset");
    rst_n = 1'b1;
    idle(2);
    chk(line, 0, "R1 line after reset");
    chk(irq, 0, "R1 irq after reset");

    // mapping table, all lines in level mode with polarity 0
    for (int i = 0; i < NV; i++) begin
      if (V_SLOT[i] == 5) tag = "R2";
      else if (V_SLOT[i] == 6 || V_SLOT[i] == 7) tag = "R3";
      else if (V_SLOT[i] >= 8 && V_SLOT[i] <= 12) tag = "R4";
      else tag = "R5";
      fire(V_SLOT[i], V_PIN[i], 1'b1);
      chk(line, V_LINE[i], tag);
    end
    idle(2);
    chk(line, 3, "R6 line holds while idle");
    chk(irq, 0, "R8 polarity 0 keeps output low");

    // edge mode on line 36 only
    edge_sel = 32'h1 << 4;
    fire(6, 2, 1'b1);
    chk(irq, 1, "R7 pulse high");
    idle(1);
    chk(irq, 0, "R7 pulse one cycle");
    idle(2);
    chk(irq, 0, "R7 stays low after pulse");
    pol_sel = 32'h1 << 4;
    fire(7, 0, 1'b1);
    chk(irq, 0, "R9 line 37 uses bit 5, not bit 4");

    // level mode
    edge_sel = '0;
    pol_sel = 32'h1 << 5;
    fire(7, 3, 1'b0);
    chk(irq, 1, "R8 level high from polarity");
    idle(3);
    chk(irq, 1, "R8 level held");
    fire(6, 0, 1'b1);
    chk(irq, 0, "R9 line 36 uses bit 4");
    pol_sel = '1;
    fire(5, 1, 1'b0);
    chk(irq, 1, "R11 level_i low ignored");
    fire(5, 1, 1'b1);
    chk(irq, 1, "R11 level_i high ignored");

    // out-of-range lines
    pol_sel = '0;
    fire(0, 3, 1'b1);
    chk(line, 3, "R5 passthrough line");
    chk(irq, 1, "R10 output kept high");
    edge_sel = '1;
    pol_sel = '1;
    fire(13, 1, 1'b1);
    chk(line, 1, "R5 passthrough slot 13");
    chk(irq, 1, "R10 no change from passthrough");
    edge_sel = '0;
    pol_sel = '0;
    fire(12, 1, 1'b1);
    chk(irq, 0, "R8 level low on line 43");
    edge_sel = '1;
    pol_sel = '1;
    fire(20, 2, 1'b1);
    chk(irq, 0, "R10 no pulse from passthrough");
    idle(1);
    chk(irq, 0, "R10 still low");

    // reset mid-run
    fire(9, 3, 1'b1);
    chk(line, 42, "R4 slot 9 pin 3");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(line, 0, "R1 async reset line");
    chk(irq, 0, "R1 async reset irq");
    idle(1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule